// File: doc/BRIEF.md
# Page Table Entry Generator

This block produces a run of 64-bit page-table entries from a short command and writes them to consecutive memory locations. A command carries a destination byte address, an initial entry value, a per-entry increment, an OR mask and a count field that holds the number of entries minus one. The block computes each entry in turn and does not read any source data.

Each entry is presented on a write port with a valid/ready handshake. The entry stays on the port until the memory side accepts it. After the final entry is accepted, the block returns to idle and pulses a completion flag. A command that arrives while a run is in progress is dropped. The driver must wait for completion before it issues the next command.

Top module: `pte_gen`

## Requirements
- R1: A command whose count field (CNT_W = 14 bits) holds N causes exactly N+1 accepted writes; a field of 0 writes one entry.
- R2: Entry i (i from 0) carries the value mask | (initial + i × increment), with the sum taken modulo 2^64.
- R3: Entry i is written at byte address dest + 8 × i, taken modulo 2^ADDR_W, so the addresses are consecutive and 8-byte spaced.
- R4: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and wr_addr_o and wr_data_o hold their values. The port moves to the next entry only after a write is accepted.
- R5: done_o is high for exactly one cycle: the cycle after the clock edge at which the last entry is accepted. wr_valid_o is low in that cycle, and done_o is never high earlier in the run.
- R6: cmd_valid_i is ignored while a run is in progress. It changes no address, value or count of the current run, and it does not start another run afterwards.
- R7: After reset, wr_valid_o and done_o are low.
- R8: A command sampled at a clock edge while the block is idle puts entry 0 on the write port in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken only while idle |
| cmd_dest_i | input | ADDR_W | Destination byte address of entry 0 |
| cmd_init_i | input | 64 | Initial entry value |
| cmd_incr_i | input | 64 | Increment added per entry |
| cmd_mask_i | input | 64 | Mask ORed into every entry |
| cmd_count_i | input | CNT_W | Number of entries minus one |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 64 | Entry value to write |
| wr_ready_i | input | 1 | Memory side accepts the write |
| done_o | output | 1 | One-cycle pulse after the last accepted write |

## Verification
The assertions assume that wr_ready_i and cmd_valid_i are known values at every edge after reset. They also assume that no write is accepted unless wr_valid_o is high. The stimulus drives ready and command inputs only at falling edges and only from the scenario tasks. The ready patterns include always-ready, one-in-three and alternating, so both the stall-hold and the advance rules are exercised. A stray command is injected mid-run to exercise the drop rule.

// File: rtl/pte_gen_pkg.sv
package pte_gen_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/pte_gen_ctrl.sv
module pte_gen_ctrl #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             running_o,
  output logic             last_o,
  output logic             done_o
);
  import pte_gen_pkg::*;

  run_state_e       state_q;
  logic [CNT_W-1:0] remain_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_RUN;
            remain_q <= count_i;
          end
        end
        ST_RUN: begin
          if (accept_i) begin
            if (remain_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              remain_q <= remain_q - 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign running_o = (state_q == ST_RUN);
  assign last_o    = running_o && (remain_q == '0);
  assign done_o    = done_q;

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R6: a start is never taken while a run is in progress
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !accept_i) |=> running_o && $stable(remain_q));
endmodule

// File: rtl/pte_gen_acc.sv
module pte_gen_acc #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] init_i,
  input  logic [DATA_W-1:0] incr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] entry_o
);
  logic [DATA_W-1:0] acc_q, incr_q, mask_q;

  // running sum replaces index * increment; wraps modulo 2^DATA_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      incr_q <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      acc_q  <= init_i;
      incr_q <= incr_i;
      mask_q <= mask_i;
    end else if (step_i) begin
      acc_q <= acc_q + incr_q;
    end
  end

  assign entry_o = mask_q | acc_q;

  // R2: operands are frozen for the whole run
  a_r2_operands_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(incr_q) && $stable(mask_q));
endmodule

// File: rtl/pte_gen_addr.sv
module pte_gen_addr #(
  parameter int ADDR_W     = 48,
  parameter int STEP_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] dest_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= dest_i;
    else if (step_i)  addr_q <= addr_q + STEP;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pte_gen.sv
module pte_gen #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_dest_i,
  input  logic [DATA_W-1:0] cmd_init_i,
  input  logic [DATA_W-1:0] cmd_incr_i,
  input  logic [DATA_W-1:0] cmd_mask_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              done_o
);
  localparam int STEP_BYTES = DATA_W / 8;

  logic running, last, start, accept, step;

  assign start  = cmd_valid_i && !running;
  assign accept = running && wr_ready_i;
  assign step   = accept && !last;

  pte_gen_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .accept_i  (accept),
    .count_i   (cmd_count_i),
    .running_o (running),
    .last_o    (last),
    .done_o    (done_o)
  );

  pte_gen_acc #(.DATA_W(DATA_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .step_i  (step),
    .init_i  (cmd_init_i),
    .incr_i  (cmd_incr_i),
    .mask_i  (cmd_mask_i),
    .entry_o (wr_data_o)
  );

  pte_gen_addr #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) i_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .step_i (step),
    .dest_i (cmd_dest_i),
    .addr_o (wr_addr_o)
  );

  assign wr_valid_o = running;

  // R4: stalled write is held unchanged
  a_r4_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R3: accepted non-final write advances the address by one entry
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i && !last) |=> wr_valid_o && (wr_addr_o == $past(wr_addr_o) + ADDR_W'(STEP_BYTES)));

  // R5: done follows the final accept, with the port idle
  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i && last) |=> done_o && !wr_valid_o);

  // R5: done never coincides with a pending write
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_valid_o);

  // R8: idle command opens a run next cycle
  a_r8_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !wr_valid_o) |=> wr_valid_o);
endmodule

// File: tb/test_pte_gen.sv
module test_pte_gen;
  localparam int  ADDR_W = 48;
  localparam int  DATA_W = 64;
  localparam int  CNT_W  = 14;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [ADDR_W-1:0] cmd_dest_i = '0;
  logic [DATA_W-1:0] cmd_init_i = '0;
  logic [DATA_W-1:0] cmd_incr_i = '0;
  logic [DATA_W-1:0] cmd_mask_i = '0;
  logic [CNT_W-1:0]  cmd_count_i = '0;
  logic              wr_valid_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;
  logic              wr_ready_i = 1'b0;
  logic              done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pte_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_pte_gen (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_dest_i, .cmd_init_i, .cmd_incr_i,
    .cmd_mask_i, .cmd_count_i, .wr_valid_o, .wr_addr_o, .wr_data_o,
    .wr_ready_i, .done_o
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode 0: always ready, 1: one in three, 2: alternating
  function automatic logic ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) == 2;
      default: return cyc[0];
    endcase
  endfunction

  task automatic run_cmd(input logic [ADDR_W-1:0] dest, input logic [63:0] init,
                         input logic [63:0] incr, input logic [63:0] mask,
                         input int count, input int mode, input bit inject);
    int n = count + 1;
    int idx = 0;
    bit stalled = 0;
    logic [ADDR_W-1:0] hold_a = '0;
    logic [63:0] hold_d = '0;
    logic [63:0] exp_d;
    logic [ADDR_W-1:0] exp_a;
    @(negedge clk_i);
    cmd_dest_i  = dest;
    cmd_init_i  = init;
    cmd_incr_i  = incr;
    cmd_mask_i  = mask;
    cmd_count_i = CNT_W'(count);
    cmd_valid_i = 1'b1;
    wr_ready_i  = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check(wr_valid_o === 1'b1, "R8 first write after command", 64'(wr_valid_o), 64'd1);
    for (int cyc = 0; cyc < 4 * n + 8; cyc++) begin
      wr_ready_i = ready_pat(mode, cyc);
      if (done_o !== 1'b0) check(0, "R5 done before last write", 64'(done_o), 64'd0);
      if (wr_valid_o !== 1'b1) begin
        check(0, "R1 run ended early", 64'(idx), 64'(n));
        break;
      end
      if (stalled) begin
        check(wr_addr_o === hold_a && wr_data_o === hold_d, "R4 stalled write held",
              64'(wr_addr_o), 64'(hold_a));
      end
      if (wr_ready_i) begin
        exp_d = mask | (init + 64'(idx) * incr);
        exp_a = dest + ADDR_W'(idx) * ADDR_W'(8);
        check(wr_data_o === exp_d, "R2 entry value", wr_data_o, exp_d);
        check(wr_addr_o === exp_a, "R3 entry address", 64'(wr_addr_o), 64'(exp_a));
        idx++;
      end
      stalled = !wr_ready_i;
      hold_a  = wr_addr_o;
      hold_d  = wr_data_o;
      if (inject && cyc == 1) begin
        cmd_dest_i  = ~dest;
        cmd_init_i  = 64'h5555_0000_AAAA_0000;
        cmd_incr_i  = 64'd1;
        cmd_mask_i  = '0;
        cmd_count_i = '1;
        cmd_valid_i = 1'b1;
      end else begin
        cmd_valid_i = 1'b0;
      end
      @(posedge clk_i);
      @(negedge clk_i);
      if (idx == n) break;
    end
    cmd_valid_i = 1'b0;
    wr_ready_i  = 1'b0;
    check(idx == n, "R1 write count", 64'(idx), 64'(n));
    check(done_o === 1'b1, "R5 done after last write", 64'(done_o), 64'd1);
    check(wr_valid_o === 1'b0, "R5 port idle with done", 64'(wr_valid_o), 64'd0);
    @(negedge clk_i);
    check(done_o === 1'b0, "R5 done single cycle", 64'(done_o), 64'd0);
    check(wr_valid_o === 1'b0, "R6 no run from dropped command", 64'(wr_valid_o), 64'd0);
  endtask

  task automatic test_reset();
    check(wr_valid_o === 1'b0, "R7 reset valid", 64'(wr_valid_o), 64'd0);
    check(done_o === 1'b0, "R7 reset done", 64'(done_o), 64'd0);
  endtask

  task automatic test_single();  // R1 count field 0
    run_cmd(48'h0000_1000_0000, 64'h0000_0000_0040_0000, 64'h1000, 64'h1, 0, 0, 0);
  endtask

  task automatic test_run_masked();  // R2 R3
    run_cmd(48'h0000_2000_0008, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_1000,
            64'h8000_0000_0000_0061, 4, 0, 0);
  endtask

  task automatic test_backpressure();  // R4
    run_cmd(48'h0000_0000_4000, 64'h123, 64'h10, 64'h0, 6, 1, 0);
    run_cmd(48'h0000_0000_8000, 64'hABC0, 64'h200, 64'hF, 5, 2, 0);
  endtask

  task automatic test_wrap();  // R2 R3 modulo behaviour
    run_cmd(48'hFFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 64'h0, 4, 0, 0);
  endtask

  task automatic test_busy_drop();  // R6
    run_cmd(48'h0000_3000_0000, 64'h7000, 64'h3, 64'h100, 5, 2, 1);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_single();
    test_run_masked();
    test_backpressure();
    test_wrap();
    test_busy_drop();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule